// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block puts a small microcontroller core to sleep and wakes it again. When software pulses a sleep request with sleep enabled and a legal 3-bit mode code, the controller turns off the core clock. Depending on the mode, it can also stop the main oscillator and the asynchronous timer clock. While asleep it watches a set of wake sources. Which sources count depends on the mode: the timer events are accepted only in the two modes that keep the timer clock running.

When a wake is accepted, the oscillator is turned on again and a stabilization delay runs before the core clock is released. If the oscillator was stopped, the delay is 2^(N+4) cycles, with N taken from a 4-bit start-up setting. If the oscillator was kept running, the delay is a short fixed count. Any reset source ends sleep or wake-up at once. A flag reports that the asynchronous timer contents cannot be trusted, because a timer-clocked mode was entered while the timer was not running from its own clock.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset, `osc_en`, `core_clk_en` and `async_clk_en` are 1, and `asleep`, `wake_done` and `async_invalid` are 0.
- R2: A request accepted in mode 3'b010 clears `osc_en`, `core_clk_en` and `async_clk_en` and sets `asleep` in the cycle after the request is sampled. The core clock never drops without a request in the previous cycle.
- R3: In mode 3'b011, `async_clk_en` stays 1 while asleep when `async_sel` is 1. If `async_sel` is 0, `async_clk_en` is 0 and `async_invalid` is set. The flag then holds through the wake, until the next accepted request recomputes it or a reset source clears it.
- R4: Modes 3'b110 and 3'b111 need `xtal_sel` = 1 and keep `osc_en` at 1 while asleep. Mode 3'b111 keeps `async_clk_en` at 1 when `async_sel` is 1. Wake latency in both modes is FAST_WAKE (6) cycles.
- R5: A request is a no-op, and the core clock stays on, in any of these cases: `sleep_en` is 0, the code is one of 000, 001, 100 or 101, or the code is 110 or 111 with `xtal_sel` = 0.
- R6: In modes 010 and 011, a wake accepted at clock edge E0 sets `osc_en` after E0. `core_clk_en` returns after edge E0+2^(N+4), where N is `startup_sel`.
- R7: `addr_match`, any bit of `edge_evt`, or a qualified level line wakes the core from every sleep mode.
- R8: A timer event wakes the core only in mode 011 or 111 with `async_sel` = 1 at entry and `gie` = 1. `tmr_ovf` also needs `ovf_ie` and `tmr_cmp` needs `cmp_ie`. In any other case the event is ignored.
- R9: A bit of `lvl_irq` counts as a wake only at the LVL_HOLD-th (4) consecutive rising edge on which it is seen high. A shorter run does nothing.
- R10: If `ext_rst`, `wdt_rst` or `bod_rst` is high at an edge, the next cycle has all clocks enabled, `asleep` at 0, `async_invalid` at 0 and no `wake_done`.
- R11: `wake_done` is high for exactly one cycle. That cycle is the first cycle of `core_clk_en` after a wake delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep request |
| sleep_en | input | 1 | Sleep permitted |
| mode | input | 3 | Sleep mode code |
| xtal_sel | input | 1 | Crystal/resonator clock option selected |
| async_sel | input | 1 | Timer clocked from its own asynchronous source |
| startup_sel | input | 4 | Start-up delay exponent N |
| gie | input | 1 | Global interrupt enable |
| ovf_ie | input | 1 | Timer overflow interrupt enable |
| cmp_ie | input | 1 | Timer compare interrupt enable |
| tmr_ovf | input | 1 | Timer overflow event |
| tmr_cmp | input | 1 | Timer compare event |
| addr_match | input | 1 | Two-wire address match event |
| edge_evt | input | 4 | External edge interrupt events |
| lvl_irq | input | 4 | External level interrupt lines |
| ext_rst | input | 1 | External reset request |
| wdt_rst | input | 1 | Watchdog reset request |
| bod_rst | input | 1 | Brown-out reset request |
| osc_en | output | 1 | Main oscillator enable |
| core_clk_en | output | 1 | CPU and I/O clock enable |
| async_clk_en | output | 1 | Asynchronous timer clock enable |
| asleep | output | 1 | Controller is in sleep |
| async_invalid | output | 1 | Timer contents undefined after wake |
| wake_done | output | 1 | One-cycle pulse when clocks return |

## Verification
The assertions check the following on every cycle:
- `wake_done` is a single pulse that lines up with the core clock coming back.
- The core clock drops only after a request.
- An illegal request leaves the core clock on.
- Reset sources restore the clocks.
- The delay counter counts down one step per cycle.
- A level line qualifies only after it was high on the previous edge.

Only the directed scenarios can show the exact wake latencies (16, 64 and 6 cycles). They also cover the per-mode wake masking, the timer enable gating, the too-short level pulse and the lifetime of the timer-invalid flag.

// File: rtl/sleep_pkg.sv
`timescale 1ns/1ps
package sleep_pkg;
  localparam logic [2:0] MODE_PDOWN = 3'b010;
  localparam logic [2:0] MODE_PSAVE = 3'b011;
  localparam logic [2:0] MODE_STBY  = 3'b110;
  localparam logic [2:0] MODE_XSTBY = 3'b111;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_WAKE   = 2'd2
  } slp_state_t;
endpackage

// File: rtl/sleep_mode_decode.sv
`timescale 1ns/1ps
module sleep_mode_decode
  import sleep_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       sleep_en,
  input  logic       xtal_sel,
  input  logic       async_sel,
  output logic       legal,
  output logic       keep_osc,
  output logic       async_run,
  output logic       async_bad
);
  logic is_pd, is_ps, is_sb, is_xs, save_class;

  always_comb begin
    is_pd      = (mode == MODE_PDOWN);
    is_ps      = (mode == MODE_PSAVE);
    is_sb      = (mode == MODE_STBY);
    is_xs      = (mode == MODE_XSTBY);
    save_class = is_ps | is_xs;
    legal      = sleep_en & (is_pd | is_ps | ((is_sb | is_xs) & xtal_sel));
    keep_osc   = is_sb | is_xs;
    async_run  = save_class & async_sel;
    async_bad  = save_class & ~async_sel;
  end
endmodule

// File: rtl/sleep_level_filter.sv
`timescale 1ns/1ps
module sleep_level_filter #(
  parameter int LINES    = 4,
  parameter int LVL_HOLD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl_in,
  output logic [LINES-1:0] lvl_qual
);
  localparam int CW = (LVL_HOLD > 2) ? $clog2(LVL_HOLD) : 1;
  localparam logic [CW-1:0] SAT = CW'(LVL_HOLD - 1);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
      if (!lvl_in[g])        cnt_d = '0;
      else if (cnt_q != SAT) cnt_d = cnt_q + CW'(1);
      else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign lvl_qual[g] = lvl_in[g] & (cnt_q == SAT);

    // R9: a qualified line was already high at the previous edge
    a_r9_level_held: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_qual[g] |-> $past(lvl_in[g]));
  end
endmodule

// File: rtl/sleep_wake_timer.sv
`timescale 1ns/1ps
module sleep_wake_timer #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             abort,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (abort)            cnt_d = '0;
    else if (load)        cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R6: delay counter steps down by one each idle cycle
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !abort && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/sleep_clk_ctrl.sv
`timescale 1ns/1ps
module sleep_clk_ctrl
  import sleep_pkg::*;
#(
  parameter int CFG_W     = 4,
  parameter int IRQ_LINES = 4,
  parameter int LVL_HOLD  = 4,
  parameter int FAST_WAKE = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep_req,
  input  logic                 sleep_en,
  input  logic [2:0]           mode,
  input  logic                 xtal_sel,
  input  logic                 async_sel,
  input  logic [CFG_W-1:0]     startup_sel,
  input  logic                 gie,
  input  logic                 ovf_ie,
  input  logic                 cmp_ie,
  input  logic                 tmr_ovf,
  input  logic                 tmr_cmp,
  input  logic                 addr_match,
  input  logic [IRQ_LINES-1:0] edge_evt,
  input  logic [IRQ_LINES-1:0] lvl_irq,
  input  logic                 ext_rst,
  input  logic                 wdt_rst,
  input  logic                 bod_rst,
  output logic                 osc_en,
  output logic                 core_clk_en,
  output logic                 async_clk_en,
  output logic                 asleep,
  output logic                 async_invalid,
  output logic                 wake_done
);
  localparam int CNT_W = (1 << CFG_W) + 3;

  slp_state_t state_q, state_d;
  logic keep_q, run_q, inval_q, done_q;
  logic take, load_tmr, done_d;
  logic dec_legal, dec_keep, dec_run, dec_bad;
  logic [IRQ_LINES-1:0] lvl_qual;
  logic any_rst, tmr_hit, wake_hit, tmr_zero;
  logic [CNT_W-1:0] ld_val;

  sleep_mode_decode u_dec (
    .mode      (mode),
    .sleep_en  (sleep_en),
    .xtal_sel  (xtal_sel),
    .async_sel (async_sel),
    .legal     (dec_legal),
    .keep_osc  (dec_keep),
    .async_run (dec_run),
    .async_bad (dec_bad)
  );

  sleep_level_filter #(.LINES(IRQ_LINES), .LVL_HOLD(LVL_HOLD)) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_in   (lvl_irq),
    .lvl_qual (lvl_qual)
  );

  always_comb begin
    any_rst  = ext_rst | wdt_rst | bod_rst;
    tmr_hit  = run_q & gie & ((tmr_ovf & ovf_ie) | (tmr_cmp & cmp_ie));
    wake_hit = addr_match | (|edge_evt) | (|lvl_qual) | tmr_hit;
    if (keep_q) ld_val = CNT_W'(FAST_WAKE - 1);
    else        ld_val = (CNT_W'(1) << (int'(startup_sel) + 4)) - CNT_W'(1);
  end

  sleep_wake_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_tmr),
    .abort    (any_rst),
    .load_val (ld_val),
    .zero     (tmr_zero)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    take     = 1'b0;
    load_tmr = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_ACTIVE: if (sleep_req && dec_legal) begin
        state_d = ST_SLEEP;
        take    = 1'b1;
      end
      ST_SLEEP: if (wake_hit) begin
        state_d  = ST_WAKE;
        load_tmr = 1'b1;
      end
      ST_WAKE: if (tmr_zero) begin
        state_d = ST_ACTIVE;
        done_d  = 1'b1;
      end
      default: state_d = ST_ACTIVE;
    endcase
    if (any_rst) begin
      state_d  = ST_ACTIVE;
      take     = 1'b0;
      load_tmr = 1'b0;
      done_d   = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      keep_q  <= 1'b0;
      run_q   <= 1'b0;
      inval_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (any_rst) begin
        keep_q  <= 1'b0;
        run_q   <= 1'b0;
        inval_q <= 1'b0;
      end else if (take) begin
        keep_q  <= dec_keep;
        run_q   <= dec_run;
        inval_q <= dec_bad;
      end
    end
  end

  always_comb begin
    core_clk_en   = (state_q == ST_ACTIVE);
    osc_en        = (state_q != ST_SLEEP) | keep_q;
    async_clk_en  = (state_q == ST_ACTIVE) | run_q;
    asleep        = (state_q == ST_SLEEP);
    async_invalid = inval_q;
    wake_done     = done_q;
  end

  // R11: wake_done lasts one cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done);
  // R11: wake_done marks the return of the core clock
  a_r11_done_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (core_clk_en && !$past(core_clk_en)));
  // R2: the core clock only drops after a request
  a_r2_drop_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> $past(sleep_req));
  // R5: an illegal request keeps the core running
  a_r5_illegal_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && sleep_req && !dec_legal) |=> core_clk_en);
  // R10: any reset source restores clocks without a done pulse
  a_r10_rst_abort: assert property (@(posedge clk) disable iff (!rst_n)
    any_rst |=> (core_clk_en && osc_en && !wake_done && !async_invalid));
endmodule

// File: tb/sleep_clk_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_clk_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic sleep_req, sleep_en, xtal_sel, async_sel, gie, ovf_ie, cmp_ie;
  logic tmr_ovf, tmr_cmp, addr_match, ext_rst, wdt_rst, bod_rst;
  logic [2:0] mode;
  logic [3:0] startup_sel, edge_evt, lvl_irq;
  logic osc_en, core_clk_en, async_clk_en, asleep, async_invalid, wake_done;
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sleep_clk_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_en(sleep_en),
    .mode(mode), .xtal_sel(xtal_sel), .async_sel(async_sel),
    .startup_sel(startup_sel), .gie(gie), .ovf_ie(ovf_ie), .cmp_ie(cmp_ie),
    .tmr_ovf(tmr_ovf), .tmr_cmp(tmr_cmp), .addr_match(addr_match),
    .edge_evt(edge_evt), .lvl_irq(lvl_irq), .ext_rst(ext_rst),
    .wdt_rst(wdt_rst), .bod_rst(bod_rst), .osc_en(osc_en),
    .core_clk_en(core_clk_en), .async_clk_en(async_clk_en), .asleep(asleep),
    .async_invalid(async_invalid), .wake_done(wake_done)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic chk(input string rq, input logic act, input logic exp);
    check(act === exp, rq, int'(act), int'(exp));
  endtask

  task automatic clear_wakes();
    addr_match = 0; edge_evt = '0; lvl_irq = '0; tmr_ovf = 0; tmr_cmp = 0;
    ext_rst = 0; wdt_rst = 0; bod_rst = 0;
  endtask

  task automatic enter(input logic [2:0] m);
    @(negedge clk); mode = m; sleep_req = 1;
    @(posedge clk);
    @(negedge clk); sleep_req = 0;
  endtask

  // wake stimulus was set before the next edge E0
  task automatic wake_seq(input int d, input string rq);
    @(posedge clk);
    @(negedge clk); clear_wakes();
    chk({rq, " osc on in wait"}, osc_en, 1'b1);
    chk({rq, " core off in wait"}, core_clk_en, 1'b0);
    repeat (d - 1) @(posedge clk);
    @(negedge clk);
    chk({rq, " core off before delay"}, core_clk_en, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk({rq, " core on after delay"}, core_clk_en, 1'b1);
    chk({rq, " R11 done pulse"}, wake_done, 1'b1);
    @(negedge clk);
    chk({rq, " R11 done single"}, wake_done, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 osc_en", osc_en, 1'b1);
    chk("R1 core_clk_en", core_clk_en, 1'b1);
    chk("R1 async_clk_en", async_clk_en, 1'b1);
    chk("R1 asleep", asleep, 1'b0);
    chk("R1 wake_done", wake_done, 1'b0);
    chk("R1 async_invalid", async_invalid, 1'b0);
  endtask

  task automatic t_noop();
    sleep_en = 0; enter(3'b010);
    chk("R5 sleep_en low", core_clk_en, 1'b1);
    sleep_en = 1;
    enter(3'b000); chk("R5 code 000", core_clk_en, 1'b1);
    enter(3'b101); chk("R5 code 101", core_clk_en, 1'b1);
    xtal_sel = 0;
    enter(3'b110); chk("R5 standby no crystal", core_clk_en, 1'b1);
    enter(3'b111); chk("R5 ext standby no crystal", core_clk_en, 1'b1);
    xtal_sel = 1;
  endtask

  task automatic t_powerdown();
    startup_sel = 4'd0; async_sel = 1; gie = 1; ovf_ie = 1;
    enter(3'b010);
    chk("R2 core off", core_clk_en, 1'b0);
    chk("R2 osc off", osc_en, 1'b0);
    chk("R2 async off", async_clk_en, 1'b0);
    chk("R2 asleep", asleep, 1'b1);
    tmr_ovf = 1;
    repeat (3) @(negedge clk);
    tmr_ovf = 0;
    chk("R8 timer ignored in power-down", asleep, 1'b1);
    addr_match = 1;
    wake_seq(16, "R6 R7 addr wake N=0");
  endtask

  task automatic t_powersave();
    startup_sel = 4'd2; async_sel = 1; gie = 0; ovf_ie = 1;
    enter(3'b011);
    chk("R3 async kept", async_clk_en, 1'b1);
    chk("R3 osc off", osc_en, 1'b0);
    chk("R3 valid", async_invalid, 1'b0);
    tmr_ovf = 1;
    repeat (3) @(negedge clk);
    chk("R8 gie low ignored", asleep, 1'b1);
    tmr_ovf = 0; gie = 1; ovf_ie = 0; tmr_ovf = 1;
    repeat (3) @(negedge clk);
    chk("R8 ovf_ie low ignored", asleep, 1'b1);
    tmr_ovf = 0; ovf_ie = 1; tmr_ovf = 1;
    wake_seq(64, "R6 R8 timer wake N=2");
    startup_sel = 4'd0;
  endtask

  task automatic t_save_invalid();
    async_sel = 0; gie = 1; ovf_ie = 1;
    enter(3'b011);
    chk("R3 async off when not async", async_clk_en, 1'b0);
    chk("R3 invalid set", async_invalid, 1'b1);
    tmr_ovf = 1;
    repeat (3) @(negedge clk);
    tmr_ovf = 0;
    chk("R8 timer ignored without async", asleep, 1'b1);
    edge_evt = 4'b0100;
    wake_seq(16, "R7 edge wake");
    chk("R3 invalid held after wake", async_invalid, 1'b1);
    enter(3'b010);
    chk("R3 invalid recomputed", async_invalid, 1'b0);
    addr_match = 1;
    wake_seq(16, "R7 addr wake 2");
  endtask

  task automatic t_level();
    enter(3'b010);
    @(negedge clk); lvl_irq = 4'b0010;
    repeat (3) @(posedge clk);
    @(negedge clk); lvl_irq = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R9 short level ignored", asleep, 1'b1);
    lvl_irq = 4'b1000;
    repeat (3) @(posedge clk);
    wake_seq(16, "R9 held level wake");
  endtask

  task automatic t_standby();
    xtal_sel = 1; async_sel = 1;
    enter(3'b110);
    chk("R4 standby osc on", osc_en, 1'b1);
    chk("R4 standby async off", async_clk_en, 1'b0);
    chk("R4 standby core off", core_clk_en, 1'b0);
    addr_match = 1;
    wake_seq(6, "R4 standby latency");
    gie = 1; cmp_ie = 1;
    enter(3'b111);
    chk("R4 ext standby osc on", osc_en, 1'b1);
    chk("R4 ext standby async on", async_clk_en, 1'b1);
    tmr_cmp = 1;
    wake_seq(6, "R4 R8 ext standby compare wake");
  endtask

  task automatic t_abort();
    enter(3'b010);
    addr_match = 1;
    @(posedge clk);
    @(negedge clk); clear_wakes();
    repeat (3) @(negedge clk);
    wdt_rst = 1;
    @(posedge clk);
    @(negedge clk); wdt_rst = 0;
    chk("R10 core on after abort", core_clk_en, 1'b1);
    chk("R10 no done on abort", wake_done, 1'b0);
    async_sel = 0;
    enter(3'b011);
    chk("R3 invalid before abort", async_invalid, 1'b1);
    bod_rst = 1;
    @(posedge clk);
    @(negedge clk); bod_rst = 0;
    chk("R10 invalid cleared", async_invalid, 1'b0);
    chk("R10 awake", asleep, 1'b0);
    chk("R10 osc on", osc_en, 1'b1);
    repeat (20) @(negedge clk);
    chk("R10 no late done", wake_done, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sleep_req = 0; sleep_en = 1; mode = 3'b000; xtal_sel = 1;
    async_sel = 0; startup_sel = 4'd0; gie = 0; ovf_ie = 0; cmp_ie = 0;
    clear_wakes();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_noop();
    t_powerdown();
    t_powersave();
    t_save_invalid();
    t_level();
    t_standby();
    t_abort();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule